// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This unit sits beside a memory-ordering queue. When a load asks to issue, the unit looks at the older entries of the queue. It starts with the entry just ahead of the load and moves toward the oldest. It settles on one of four outcomes:

- forward the value of an older store straight to the load;
- stall the load because an older store overlaps it in a way that cannot be forwarded;
- send the load to the cache;
- hold the load because the cache request queue is full.

The search is one combinational priority pass over all queue slots, and the outcome is captured in a register. A forwarded load is reported complete one cycle after the outcome is registered.

Forwarding follows the operation types of the store and the load:

- Byte, halfword and word stores feed loads of the same size. Signed loads get sign extension and unsigned loads get zero extension.
- A single-float store and a word store can feed each other's loads.
- A 64-bit store feeds only a 64-bit load of the same kind.
- An atomic set-byte store supplies the constant 255 to an unsigned byte load.
- A double-float store can supply either 32-bit half to an unsigned word load.

Older stores whose addresses are still unknown are passed over. The load is then marked as speculative.

Top module: `stlf_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared on that edge: `dec_vld`, `partial`, `spec` and `fwd_done` are 0, and `dec_kind`, `fwd_data` and `fwd_tag` are 0. This holds even when `ld_req` is high.
- R2: Queue slot 0 is the entry just ahead of the load, and slot DEPTH-1 is the oldest. Slots with `ent_vld` low and slots holding loads (`ent_store` low) are skipped. The first valid store with a known address that overlaps the load, counting from slot 0, alone decides the outcome. `fwd_tag` carries that store's tag.
- R3: A valid store with `ent_addr_rdy` low never ends the search, whatever its address fields hold. If such a store lies ahead of the deciding point, `spec` is 1 together with an ISSUE or FORWARD outcome. `spec` is 0 with every other outcome.
- R4: Two accesses overlap when either access's last byte address lies inside the other's inclusive [start, end] range. Accesses that only touch neighbouring addresses do not overlap.
- R5: Operation codes are 0 unsigned byte, 1 signed byte, 2 unsigned half, 3 signed half, 4 unsigned word, 5 signed word, 6 single float, 7 64-bit integer, 8 double float and 9 atomic set-byte. Forwarding needs equal start addresses. Store data sits right-aligned in `ent_data`. A word store (code 4 or 5) feeds code 5 with sign extension from bit 31, code 4 with zero extension, and code 6 with the raw 32 bits and zero upper bits.
- R6: A byte store (code 0 or 1) feeds byte loads, and a half store (code 2 or 3) feeds half loads. Signed loads are sign-extended and unsigned loads are zero-extended. A single-float store feeds code 6 raw, code 4 zero-extended and code 5 sign-extended. Code 7 feeds only code 7, and code 8 feeds code 8, each with all 64 bits. Every other type pair that overlaps stalls.
- R7: An atomic set-byte store forwards the value 255 to an unsigned byte load at the same address. Any other overlapping load stalls.
- R8: A double-float store at address A feeds an unsigned word load at A with data bits 63:32, and one at A+4 with bits 31:0. Any other overlap that cannot be forwarded gives a STALL with `partial` = 1.
- R9: An overlapping store whose data is not ready (`ent_data_rdy` low) cannot be forwarded. The load stalls with `partial` = 1.
- R10: `dec_kind` encodes 0 HOLD, 1 ISSUE, 2 STALL and 3 FORWARD. If no store overlaps, the outcome is ISSUE when `cq_full` is 0 and HOLD when it is 1. A FORWARD or STALL outcome does not depend on `cq_full`.
- R11: The outcome for a request sampled at one clock edge appears with `dec_vld` = 1 after that edge. `dec_vld` is 0 after any edge at which `ld_req` was 0. `fwd_done` pulses for exactly one cycle, on the cycle after a FORWARD outcome, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req | input | 1 | A load asks to issue this cycle |
| ld_op | input | 4 | Load operation code |
| ld_addr | input | AW | Load start byte address |
| ld_end | input | AW | Load last byte address |
| cq_full | input | 1 | Cache request queue is full |
| ent_vld | input | DEPTH | Slot holds a live older entry |
| ent_store | input | DEPTH | Slot holds a store (0 = load) |
| ent_addr_rdy | input | DEPTH | Slot address is known |
| ent_data_rdy | input | DEPTH | Slot store data is ready |
| ent_op | input | DEPTH*4 | Per-slot operation codes |
| ent_addr | input | DEPTH*AW | Per-slot start addresses |
| ent_end | input | DEPTH*AW | Per-slot last byte addresses |
| ent_data | input | DEPTH*64 | Per-slot store data |
| ent_tag | input | DEPTH*TW | Per-slot tags |
| dec_vld | output | 1 | Registered outcome is valid |
| dec_kind | output | 2 | Outcome: HOLD, ISSUE, STALL or FORWARD |
| fwd_data | output | 64 | Forwarded value, extended to 64 bits |
| fwd_tag | output | TW | Tag of the store that decided the outcome |
| spec | output | 1 | Load went past stores whose addresses are unknown |
| partial | output | 1 | Stall caused by an overlap that cannot be forwarded |
| fwd_done | output | 1 | Forwarded load completes |

## Verification
The assertions assume that the queue contents and the load fields are stable during each cycle in which `ld_req` is high. They also assume that each end address is no lower than its start address. The bench drives every input on the falling edge and builds each end address from the operation size, so both assumptions always hold. Slots that the bench does not use are marked invalid. Only the store under test, together with the younger loads, younger stores and address-unknown stores placed on purpose, can take part in the search.

// File: rtl/stlf_pkg.sv
// Package: shared operation and outcome encodings for the forwarding search.
// Assumes a 64-bit store data path; the operation codes are fixed by the queue.
package stlf_pkg;

    localparam int DW = 64;

    typedef enum logic [3:0] {
        OP_BU = 4'd0,
        OP_BS = 4'd1,
        OP_HU = 4'd2,
        OP_HS = 4'd3,
        OP_WU = 4'd4,
        OP_WS = 4'd5,
        OP_SF = 4'd6,
        OP_DI = 4'd7,
        OP_DF = 4'd8,
        OP_SB = 4'd9
    } mem_op_e;

    typedef enum logic [1:0] {
        DEC_HOLD  = 2'd0,
        DEC_ISSUE = 2'd1,
        DEC_STALL = 2'd2,
        DEC_FWD   = 2'd3
    } dec_e;

    function automatic logic [DW-1:0] sext8(input logic [7:0] v);
        return {{(DW-8){v[7]}}, v};
    endfunction

    function automatic logic [DW-1:0] sext16(input logic [15:0] v);
        return {{(DW-16){v[15]}}, v};
    endfunction

    function automatic logic [DW-1:0] sext32(input logic [31:0] v);
        return {{(DW-32){v[31]}}, v};
    endfunction

endpackage

// File: rtl/stlf_overlap.sv
// Module: stlf_overlap
// Decides whether two byte ranges share at least one byte.
// Assumes each end address is not below its start address (inclusive ranges).
module stlf_overlap #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] a_start,
    input  logic [AW-1:0] a_end,
    input  logic [AW-1:0] b_start,
    input  logic [AW-1:0] b_end,
    output logic          hit
);

    logic a_end_in_b;
    logic b_end_in_a;

    // Check whether either range's last byte falls inside the other range.
    always_comb begin
        b_end_in_a = (a_end >= b_end) && (b_end >= a_start);
        a_end_in_b = (b_end >= a_end) && (a_end >= b_start);
        hit        = a_end_in_b || b_end_in_a;
    end

endmodule

// File: rtl/stlf_match.sv
// Module: stlf_match
// Type compatibility check between one older store and the requesting load.
// Produces the forwarded value, already extended to 64 bits.
// Assumes the caller has already found that the two accesses overlap.
module stlf_match #(
    parameter int AW = 32
) (
    input  logic [3:0]           st_op,
    input  logic [AW-1:0]        st_addr,
    input  logic [stlf_pkg::DW-1:0] st_data,
    input  logic [3:0]           ld_op,
    input  logic [AW-1:0]        ld_addr,
    output logic                 ok,
    output logic [stlf_pkg::DW-1:0] val
);
    import stlf_pkg::*;

    logic    same;
    logic    second_word;
    mem_op_e sop;
    mem_op_e lop;

    // Decode both operation codes and compare the addresses.
    always_comb begin
        sop         = mem_op_e'(st_op);
        lop         = mem_op_e'(ld_op);
        same        = (st_addr == ld_addr);
        second_word = (ld_addr == st_addr + AW'(4));
    end

    // Select the forwarded value from the store type and the load type.
    always_comb begin
        ok  = 1'b0;
        val = '0;
        unique case (sop)
            OP_BU, OP_BS: begin
                if (same && (lop == OP_BU || lop == OP_BS)) begin
                    ok  = 1'b1;
                    val = (lop == OP_BS) ? sext8(st_data[7:0])
                                         : {{(DW-8){1'b0}}, st_data[7:0]};
                end
            end
            OP_HU, OP_HS: begin
                if (same && (lop == OP_HU || lop == OP_HS)) begin
                    ok  = 1'b1;
                    val = (lop == OP_HS) ? sext16(st_data[15:0])
                                         : {{(DW-16){1'b0}}, st_data[15:0]};
                end
            end
            OP_WU, OP_WS, OP_SF: begin
                if (same && (lop == OP_WU || lop == OP_WS || lop == OP_SF)) begin
                    ok  = 1'b1;
                    val = (lop == OP_WS) ? sext32(st_data[31:0])
                                         : {{(DW-32){1'b0}}, st_data[31:0]};
                end
            end
            OP_DI: begin
                if (same && lop == OP_DI) begin
                    ok  = 1'b1;
                    val = st_data;
                end
            end
            OP_DF: begin
                if (same && lop == OP_DF) begin
                    ok  = 1'b1;
                    val = st_data;
                end else if (lop == OP_WU && same) begin
                    ok  = 1'b1;
                    val = {{(DW-32){1'b0}}, st_data[63:32]};
                end else if (lop == OP_WU && second_word) begin
                    ok  = 1'b1;
                    val = {{(DW-32){1'b0}}, st_data[31:0]};
                end
            end
            OP_SB: begin
                if (same && lop == OP_BU) begin
                    ok  = 1'b1;
                    val = DW'(255);
                end
            end
            default: begin
                ok  = 1'b0;
                val = '0;
            end
        endcase
    end

endmodule

// File: rtl/stlf_scan.sv
// Module: stlf_scan
// Priority search from slot 0 (youngest older entry) toward slot DEPTH-1.
// Skips loads and invalid slots, notes stores whose address is unknown,
// and stops at the first overlapping store with a known address.
module stlf_scan #(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vld,
    input  logic [DEPTH-1:0] store,
    input  logic [DEPTH-1:0] addr_rdy,
    input  logic [DEPTH-1:0] ovl,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output logic             spec
);

    // Walk the slots in age order and stop at the first deciding store.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        spec    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit && vld[i] && store[i]) begin
                if (!addr_rdy[i]) begin
                    spec = 1'b1;
                end else if (ovl[i]) begin
                    hit     = 1'b1;
                    hit_idx = IW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/stlf_unit.sv
// Module: stlf_unit (top)
// Store-to-load forwarding search: finds the first overlapping older store,
// then forwards, stalls, issues or holds the load, and registers the outcome.
// Assumes the queue contents are stable during a request cycle.
module stlf_unit #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int TW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_req,
    input  logic [3:0]           ld_op,
    input  logic [AW-1:0]        ld_addr,
    input  logic [AW-1:0]        ld_end,
    input  logic                 cq_full,
    input  logic [DEPTH-1:0]     ent_vld,
    input  logic [DEPTH-1:0]     ent_store,
    input  logic [DEPTH-1:0]     ent_addr_rdy,
    input  logic [DEPTH-1:0]     ent_data_rdy,
    input  logic [DEPTH*4-1:0]   ent_op,
    input  logic [DEPTH*AW-1:0]  ent_addr,
    input  logic [DEPTH*AW-1:0]  ent_end,
    input  logic [DEPTH*64-1:0]  ent_data,
    input  logic [DEPTH*TW-1:0]  ent_tag,
    output logic                 dec_vld,
    output logic [1:0]           dec_kind,
    output logic [63:0]          fwd_data,
    output logic [TW-1:0]        fwd_tag,
    output logic                 spec,
    output logic                 partial,
    output logic                 fwd_done
);
    import stlf_pkg::*;

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] ovl;
    logic [DEPTH-1:0] m_ok;
    logic [DW-1:0]    m_val [DEPTH];
    logic [TW-1:0]    tag_a [DEPTH];

    logic          s_hit;
    logic [IW-1:0] s_idx;
    logic          s_spec;

    dec_e          nx_kind;
    logic [DW-1:0] nx_data;
    logic [TW-1:0] nx_tag;
    logic          nx_partial;
    logic          nx_spec;

    // One overlap test and one type matcher per queue slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        stlf_overlap #(.AW(AW)) u_ovl (
            .a_start (ent_addr[g*AW +: AW]),
            .a_end   (ent_end[g*AW +: AW]),
            .b_start (ld_addr),
            .b_end   (ld_end),
            .hit     (ovl[g])
        );

        stlf_match #(.AW(AW)) u_match (
            .st_op   (ent_op[g*4 +: 4]),
            .st_addr (ent_addr[g*AW +: AW]),
            .st_data (ent_data[g*DW +: DW]),
            .ld_op   (ld_op),
            .ld_addr (ld_addr),
            .ok      (m_ok[g]),
            .val     (m_val[g])
        );

        assign tag_a[g] = ent_tag[g*TW +: TW];
    end

    stlf_scan #(.DEPTH(DEPTH)) u_scan (
        .vld      (ent_vld),
        .store    (ent_store),
        .addr_rdy (ent_addr_rdy),
        .ovl      (ovl),
        .hit      (s_hit),
        .hit_idx  (s_idx),
        .spec     (s_spec)
    );

    // Turn the search result and the queue-full state into an outcome.
    always_comb begin
        nx_kind    = DEC_HOLD;
        nx_data    = '0;
        nx_tag     = '0;
        nx_partial = 1'b0;
        if (s_hit) begin
            nx_tag = tag_a[s_idx];
            if (ent_data_rdy[s_idx] && m_ok[s_idx]) begin
                nx_kind = DEC_FWD;
                nx_data = m_val[s_idx];
            end else begin
                nx_kind    = DEC_STALL;
                nx_partial = 1'b1;
            end
        end else if (!cq_full) begin
            nx_kind = DEC_ISSUE;
        end
        nx_spec = s_spec && (nx_kind == DEC_ISSUE || nx_kind == DEC_FWD);
    end

    // Register the outcome; cleared by reset or when no load asks to issue.
    always_ff @(posedge clk) begin
        if (!rst_n || !ld_req) begin
            dec_vld  <= 1'b0;
            dec_kind <= DEC_HOLD;
            fwd_data <= '0;
            fwd_tag  <= '0;
            spec     <= 1'b0;
            partial  <= 1'b0;
        end else begin
            dec_vld  <= 1'b1;
            dec_kind <= nx_kind;
            fwd_data <= nx_data;
            fwd_tag  <= nx_tag;
            spec     <= nx_spec;
            partial  <= nx_partial;
        end
    end

    // Report completion of a forwarded load one cycle after its outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_done <= 1'b0;
        end else begin
            fwd_done <= dec_vld && (dec_kind == DEC_FWD);
        end
    end

endmodule

// File: rtl/stlf_unit_chk.sv
// Module: stlf_unit_chk
// Temporal checks on the forwarding unit's ports, attached by bind.
// Assumes a synchronous active-low reset.
module stlf_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ld_req,
    input logic       cq_full,
    input logic       dec_vld,
    input logic [1:0] dec_kind,
    input logic       spec,
    input logic       partial,
    input logic       fwd_done
);

    // R11
    fwd_done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_kind == 2'd3) |=> fwd_done);

    // R11
    fwd_done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_done |-> $past(dec_vld && dec_kind == 2'd3));

    // R11
    no_req_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> !dec_vld);

    // R10
    full_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && cq_full) |=> (dec_kind != 2'd1));

    // R8
    partial_is_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        partial |-> (dec_vld && dec_kind == 2'd2));

    // R3
    spec_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec |-> (dec_vld && (dec_kind == 2'd1 || dec_kind == 2'd3)));

endmodule

bind stlf_unit stlf_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_req   (ld_req),
    .cq_full  (cq_full),
    .dec_vld  (dec_vld),
    .dec_kind (dec_kind),
    .spec     (spec),
    .partial  (partial),
    .fwd_done (fwd_done)
);

// File: tb/stlf_unit_bench.sv
`timescale 1ns/1ps
module stlf_unit_bench;

    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int TW    = 8;

    localparam logic [3:0] BU = 4'd0, BS = 4'd1, HU = 4'd2, HS = 4'd3,
                           WU = 4'd4, WS = 4'd5, SF = 4'd6, DI = 4'd7,
                           DF = 4'd8, SB = 4'd9;
    localparam logic [1:0] K_HOLD = 2'd0, K_ISSUE = 2'd1, K_STALL = 2'd2, K_FWD = 2'd3;
    localparam logic [63:0] SD = 64'h8899AABB_CCDDEEF0;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ld_req = 1'b0;
    logic [3:0]          ld_op = '0;
    logic [AW-1:0]       ld_addr = '0;
    logic [AW-1:0]       ld_end = '0;
    logic                cq_full = 1'b0;
    logic [DEPTH-1:0]    ent_vld = '0;
    logic [DEPTH-1:0]    ent_store = '0;
    logic [DEPTH-1:0]    ent_addr_rdy = '0;
    logic [DEPTH-1:0]    ent_data_rdy = '0;
    logic [DEPTH*4-1:0]  ent_op = '0;
    logic [DEPTH*AW-1:0] ent_addr = '0;
    logic [DEPTH*AW-1:0] ent_end = '0;
    logic [DEPTH*64-1:0] ent_data = '0;
    logic [DEPTH*TW-1:0] ent_tag = '0;
    logic                dec_vld;
    logic [1:0]          dec_kind;
    logic [63:0]         fwd_data;
    logic [TW-1:0]       fwd_tag;
    logic                spec;
    logic                partial;
    logic                fwd_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    stlf_unit #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_stlf_unit (.*);

    typedef struct packed {
        logic [3:0]  lop;
        logic [31:0] laddr;
        logic [3:0]  sop;
        logic [31:0] saddr;
        logic [1:0]  kind;
        logic [63:0] val;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{BU, 32'h100, BU, 32'h100, K_FWD,   64'hF0},
        '{BS, 32'h100, BS, 32'h100, K_FWD,   64'hFFFFFFFF_FFFFFFF0},
        '{HS, 32'h100, HU, 32'h100, K_FWD,   64'hFFFFFFFF_FFFFEEF0},
        '{HU, 32'h100, HS, 32'h100, K_FWD,   64'hEEF0},
        '{WS, 32'h100, WU, 32'h100, K_FWD,   64'hFFFFFFFF_CCDDEEF0},
        '{WU, 32'h100, WS, 32'h100, K_FWD,   64'hCCDDEEF0},
        '{SF, 32'h100, WU, 32'h100, K_FWD,   64'hCCDDEEF0},
        '{WS, 32'h100, SF, 32'h100, K_FWD,   64'hFFFFFFFF_CCDDEEF0},
        '{DI, 32'h100, DI, 32'h100, K_FWD,   SD},
        '{DF, 32'h100, DF, 32'h100, K_FWD,   SD},
        '{WU, 32'h100, DF, 32'h100, K_FWD,   64'h8899AABB},
        '{WU, 32'h104, DF, 32'h100, K_FWD,   64'hCCDDEEF0},
        '{WS, 32'h104, DF, 32'h100, K_STALL, 64'h0},
        '{BU, 32'h100, SB, 32'h100, K_FWD,   64'hFF},
        '{BS, 32'h100, SB, 32'h100, K_STALL, 64'h0},
        '{BU, 32'h102, WU, 32'h100, K_STALL, 64'h0},
        '{WU, 32'h104, WU, 32'h100, K_ISSUE, 64'h0},
        '{WU, 32'h0FC, BU, 32'h100, K_ISSUE, 64'h0},
        '{WU, 32'h100, BU, 32'h103, K_STALL, 64'h0},
        '{BU, 32'h100, HU, 32'h100, K_STALL, 64'h0},
        '{DI, 32'h100, DF, 32'h100, K_STALL, 64'h0},
        '{DF, 32'h104, DF, 32'h100, K_STALL, 64'h0}
    };

    function automatic logic [AW-1:0] last_byte(input logic [3:0] op, input logic [AW-1:0] a);
        case (op)
            BU, BS, SB:     return a;
            HU, HS:         return a + 1;
            WU, WS, SF:     return a + 3;
            default:        return a + 7;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_ents();
        ent_vld = '0; ent_store = '0; ent_addr_rdy = '0; ent_data_rdy = '0;
        ent_op = '0; ent_addr = '0; ent_end = '0; ent_data = '0; ent_tag = '0;
    endtask

    task automatic set_ent(input int i, input bit st, input bit ar, input bit dr,
                           input logic [3:0] op, input logic [AW-1:0] a,
                           input logic [63:0] d, input logic [TW-1:0] t);
        ent_vld[i] = 1'b1; ent_store[i] = st; ent_addr_rdy[i] = ar; ent_data_rdy[i] = dr;
        ent_op[i*4 +: 4] = op;
        ent_addr[i*AW +: AW] = a;
        ent_end[i*AW +: AW] = last_byte(op, a);
        ent_data[i*64 +: 64] = d;
        ent_tag[i*TW +: TW] = t;
    endtask

    // Drive a request on a falling edge, sample the outcome one edge later.
    task automatic run_load(input logic [3:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        ld_op = op; ld_addr = a; ld_end = last_byte(op, a); ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: synchronous reset clears outputs even with a request pending
        clear_ents();
        set_ent(0, 1, 1, 1, WU, 32'h100, SD, 8'h21);
        ld_op = WU; ld_addr = 32'h100; ld_end = 32'h103; ld_req = 1'b1;
        repeat (3) @(negedge clk);
        check(!dec_vld && !fwd_done && !spec && !partial && dec_kind == 0 && fwd_data == 0 && fwd_tag == 0,
              "R1 reset", {dec_vld, fwd_done, spec, partial, dec_kind, fwd_tag}, 64'd0);
        ld_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R4 R5 R6 R7 R8, one store at slot 0
        for (int v = 0; v < NV; v++) begin
            clear_ents();
            set_ent(0, 1, 1, 1, VECS[v].sop, VECS[v].saddr, SD, 8'h21);
            run_load(VECS[v].lop, VECS[v].laddr);
            check(dec_vld && dec_kind == VECS[v].kind, $sformatf("R5/R6/R7/R8/R4 kind vec %0d", v),
                  {62'd0, dec_kind}, {62'd0, VECS[v].kind});
            if (VECS[v].kind == K_FWD)
                check(fwd_data == VECS[v].val && fwd_tag == 8'h21,
                      $sformatf("R5/R6/R7/R8 data vec %0d", v), fwd_data, VECS[v].val);
            check(partial == (VECS[v].kind == K_STALL) && !spec,
                  $sformatf("R8 partial vec %0d", v), {62'd0, partial, spec},
                  {62'd0, VECS[v].kind == K_STALL, 1'b0});
        end

        // R2: younger load skipped, nearest store wins over older one
        clear_ents();
        set_ent(0, 0, 1, 1, WU, 32'h100, 64'h0, 8'h10);
        set_ent(1, 1, 1, 1, BU, 32'h200, 64'h77, 8'h1F);
        set_ent(2, 1, 1, 1, WU, 32'h100, 64'h11111111, 8'h11);
        set_ent(3, 1, 1, 1, WU, 32'h100, 64'h22222222, 8'h12);
        run_load(WU, 32'h100);
        check(dec_kind == K_FWD && fwd_data == 64'h11111111 && fwd_tag == 8'h11,
              "R2 priority", {fwd_tag, fwd_data[31:0]}, {8'h11, 32'h11111111});

        // R2: oldest slot can decide
        clear_ents();
        set_ent(7, 1, 1, 1, HU, 32'h300, 64'hBEEF, 8'h77);
        run_load(HU, 32'h300);
        check(dec_kind == K_FWD && fwd_data == 64'hBEEF && fwd_tag == 8'h77,
              "R2 oldest slot", fwd_data, 64'hBEEF);

        // R3: unknown-address store skipped, forward is speculative
        clear_ents();
        set_ent(0, 1, 0, 1, BU, 32'h100, 64'h55, 8'h30);
        set_ent(1, 1, 1, 1, WU, 32'h100, 64'hA5A5A5A5, 8'h31);
        run_load(WU, 32'h100);
        check(dec_kind == K_FWD && spec && fwd_tag == 8'h31, "R3 spec forward",
              {fwd_tag, 6'd0, spec, 1'b0}, {8'h31, 8'h02});

        // R3: unknown-address store with no hit gives speculative issue
        clear_ents();
        set_ent(0, 1, 0, 1, WU, 32'h100, 64'h0, 8'h30);
        run_load(WU, 32'h100);
        check(dec_kind == K_ISSUE && spec, "R3 spec issue", {spec, dec_kind}, {1'b1, K_ISSUE});

        // R3 R9: stall after unknown store reports no spec; data not ready stalls
        clear_ents();
        set_ent(0, 1, 0, 1, WU, 32'h100, 64'h0, 8'h30);
        set_ent(1, 1, 1, 0, WU, 32'h100, 64'h1234, 8'h32);
        run_load(WU, 32'h100);
        check(dec_kind == K_STALL && partial && !spec, "R9 data not ready / R3",
              {partial, spec, dec_kind}, {1'b1, 1'b0, K_STALL});

        // R10: full queue holds a plain load
        clear_ents();
        cq_full = 1'b1;
        run_load(WU, 32'h100);
        check(dec_vld && dec_kind == K_HOLD, "R10 hold when full", {62'd0, dec_kind}, {62'd0, K_HOLD});

        // R10: full queue does not block a forward
        set_ent(0, 1, 1, 1, WU, 32'h100, 64'h0BADF00D, 8'h40);
        run_load(WU, 32'h100);
        check(dec_kind == K_FWD && fwd_data == 64'h0BADF00D, "R10 forward while full", fwd_data, 64'h0BADF00D);
        // R11: completion pulse on the next cycle, then gone
        @(negedge clk);
        check(fwd_done && !dec_vld, "R11 fwd_done pulse", {fwd_done, dec_vld}, 2'b10);
        @(negedge clk);
        check(!fwd_done, "R11 fwd_done single", {63'd0, fwd_done}, 64'd0);
        cq_full = 1'b0;

        // R11: no completion after an issue
        clear_ents();
        run_load(WU, 32'h500);
        check(dec_kind == K_ISSUE, "R11 issue outcome", {62'd0, dec_kind}, {62'd0, K_ISSUE});
        @(negedge clk);
        check(!fwd_done && !dec_vld, "R11 no fwd_done after issue", {fwd_done, dec_vld}, 2'b00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule